// File: doc/BRIEF.md
# Timer Output Compare and PWM Channel

This block is a 16-bit up-counting timer with a single compare output. A programmable prescaler divides the system clock into counter ticks. The counter climbs from zero to a reload limit and then wraps. On each pass it compares its value against a compare register and drives one output pin in one of six ways:

- leave the pin alone;
- force it high on a match;
- force it low on a match;
- flip it on a match;
- produce an edge-aligned PWM waveform;
- produce the same PWM waveform with the opposite active phase.

A sticky match flag records compare events until software clears it.

Software programs the block through a plain register-write port (write strobe, address, data). Every write is taken in the cycle it is presented, so there is no back-pressure. The limit and prescaler values written while the timer runs are buffered and take effect at the next wrap, called the update event. The compare value can be buffered in the same way when preload is enabled, which makes duty-cycle changes glitch-free. The pin and the flag are registered and change on the clock edge on which the counter moves to a new value.

Top module: `tmr_oc_pwm`

## Requirements
- R1: While enable (control bit 4) is 1, the counter advances once every PSC+1 clocks. While enable is 0, the counter, the prescaler and the pin hold their values.
- R2: The counter runs 0,1,…,ARR and then returns to 0, so one period lasts (ARR+1)·(PSC+1) clocks.
- R3: Writing to address 4 clears the match flag. The flag is set when the counter moves onto the compare value, and it stays set until the next clear. When a set and a clear happen in the same cycle, the set wins. If the compare value is above ARR, the flag never sets.
- R4: The mode field is control bits 2:0. Mode 3'b011 inverts the pin on each compare match.
- R5: Mode 3'b001 drives the pin to 1 on a match, and mode 3'b010 drives it to 0 on a match. Mode 3'b000 never changes the pin.
- R6: Mode 3'b110 drives the pin to 1 for counter values below CCR and to 0 otherwise. With CCR=0 the pin is always 0, and with CCR>ARR it is always 1.
- R7: Mode 3'b111 is the inverse of mode 3'b110. For counter values below CCR the pin is 0, and from CCR up to the wrap it is 1. With CCR=0 the pin is always 1, and with CCR>ARR it is always 0.
- R8: With preload (control bit 3) at 1, a compare write (address 2) made while the timer runs is held until the next wrap. With preload at 0, a compare write takes effect at once.
- R9: A prescaler write (address 0) or a limit write (address 1) made while the timer runs takes effect at the next wrap. The same write made while the timer is stopped takes effect at once.
- R10: Reset (rst_n low, asynchronous) clears the counter, the prescaler count, the flag and the pin to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe, always accepted |
| cfg_addr | input | 3 | 0 prescaler, 1 limit, 2 compare, 3 control, 4 flag clear |
| cfg_wdata | input | 16 | Write data |
| pin_out | output | 1 | Compare channel output |
| match_flag | output | 1 | Sticky compare match flag |

## Verification
The bench counts high cycles, rising edges and pin changes over windows that are whole numbers of periods. This makes the checks independent of phase, and it shows up a prescaler or wrap that is off by one as a wrong period, and a swapped PWM phase as an inverted duty. It drives the compare value to 0 and above the limit in both PWM modes. A design that compares with the wrong inequality would leave a one-tick sliver in those cases. A design that matches past the limit would set the flag when no match is possible.

For preload, the bench rewrites the compare value just after the falling edge of the pin. An unbuffered design would re-raise the pin inside the current period, while the immediate mode must do exactly that. A limit change made while the timer runs must show up only as a new period after settling. Stopping the timer and choosing the hold mode must each freeze the pin.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    MD_FROZEN = 3'b000,
    MD_SET    = 3'b001,
    MD_CLR    = 3'b010,
    MD_TOG    = 3'b011,
    MD_PWM1   = 3'b110,
    MD_PWM2   = 3'b111
  } oc_mode_e;

  localparam logic [2:0] A_PSC  = 3'd0;
  localparam logic [2:0] A_ARR  = 3'd1;
  localparam logic [2:0] A_CCR  = 3'd2;
  localparam logic [2:0] A_CTRL = 3'd3;
  localparam logic [2:0] A_FCLR = 3'd4;

  localparam int CTRL_PRE_BIT = 3;
  localparam int CTRL_EN_BIT  = 4;
endpackage

// File: rtl/tmr_shadow.sv
module tmr_shadow #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         buffered,
  input  logic         uev,
  output logic [W-1:0] act,
  output logic [W-1:0] act_nxt
);
  logic [W-1:0] shadow_q;

  always_comb begin
    act_nxt = act;
    if (we && !buffered)
      act_nxt = wdata;
    else if (uev && buffered)
      act_nxt = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act      <= '0;
    end else begin
      if (we) shadow_q <= wdata;
      act <= act_nxt;
    end
  end

  // R8
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buffered && !uev) |=> $stable(act));
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase #(
  parameter int W  = 16,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] psc,
  input  logic [W-1:0]  arr,
  output logic          tick,
  output logic          uev,
  output logic [W-1:0]  cnt,
  output logic [W-1:0]  cnt_nxt
);
  logic [PW-1:0] pcnt_q;
  logic          at_top;

  assign tick   = en && (pcnt_q >= psc);
  assign at_top = (cnt >= arr);
  assign uev    = tick && at_top;

  always_comb begin
    cnt_nxt = cnt;
    if (tick) cnt_nxt = at_top ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      cnt    <= '0;
    end else begin
      if (tick)    pcnt_q <= '0;
      else if (en) pcnt_q <= pcnt_q + 1'b1;
      cnt <= cnt_nxt;
    end
  end

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  // R1
  pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pcnt_q == '0));
  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_top) |=> (cnt == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] ccr_nxt,
  input  oc_mode_e     mode,
  input  logic         clr,
  output logic         pin,
  output logic         flag
);
  logic hit;
  logic below;

  assign hit   = tick && (cnt_nxt == ccr_nxt);
  assign below = (cnt_nxt < ccr_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin  <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      case (mode)
        MD_SET:  if (hit)  pin <= 1'b1;
        MD_CLR:  if (hit)  pin <= 1'b0;
        MD_TOG:  if (hit)  pin <= ~pin;
        MD_PWM1: if (tick) pin <= below;
        MD_PWM2: if (tick) pin <= ~below;
        default: pin <= pin;
      endcase
    end
  end

  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag);
  // R4
  tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_TOG && hit) |=> (pin != $past(pin)));
  // R5
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_FROZEN) |=> $stable(pin));
  // R7
  pwm2_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PWM2 && tick && ccr_nxt == '0) |=> pin);
endmodule

// File: rtl/tmr_oc_pwm.sv
module tmr_oc_pwm
  import tmr_pkg::*;
#(
  parameter int W  = 16,
  parameter int PW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [15:0] cfg_wdata,
  output logic        pin_out,
  output logic        match_flag
);
  logic [2:0]    mode_q;
  logic          pre_q;
  logic          en_q;
  logic          wr_psc, wr_arr, wr_ccr, wr_ctrl, wr_fclr;
  logic          tick, uev;
  logic [W-1:0]  cnt, cnt_nxt;
  logic [PW-1:0] psc_act, psc_nxt;
  logic [W-1:0]  arr_act, arr_nxt, ccr_act, ccr_nxt;

  assign wr_psc  = cfg_we && (cfg_addr == A_PSC);
  assign wr_arr  = cfg_we && (cfg_addr == A_ARR);
  assign wr_ccr  = cfg_we && (cfg_addr == A_CCR);
  assign wr_ctrl = cfg_we && (cfg_addr == A_CTRL);
  assign wr_fclr = cfg_we && (cfg_addr == A_FCLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_FROZEN;
      pre_q  <= 1'b0;
      en_q   <= 1'b0;
    end else if (wr_ctrl) begin
      mode_q <= cfg_wdata[2:0];
      pre_q  <= cfg_wdata[CTRL_PRE_BIT];
      en_q   <= cfg_wdata[CTRL_EN_BIT];
    end
  end

  tmr_shadow #(.W(PW)) u_psc (
    .clk(clk), .rst_n(rst_n), .we(wr_psc), .wdata(cfg_wdata[PW-1:0]),
    .buffered(en_q), .uev(uev), .act(psc_act), .act_nxt(psc_nxt));

  tmr_shadow #(.W(W)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(wr_arr), .wdata(cfg_wdata[W-1:0]),
    .buffered(en_q), .uev(uev), .act(arr_act), .act_nxt(arr_nxt));

  tmr_shadow #(.W(W)) u_ccr (
    .clk(clk), .rst_n(rst_n), .we(wr_ccr), .wdata(cfg_wdata[W-1:0]),
    .buffered(en_q && pre_q), .uev(uev), .act(ccr_act), .act_nxt(ccr_nxt));

  tmr_timebase #(.W(W), .PW(PW)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(en_q), .psc(psc_act), .arr(arr_act),
    .tick(tick), .uev(uev), .cnt(cnt), .cnt_nxt(cnt_nxt));

  tmr_channel #(.W(W)) u_ch (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_nxt(cnt_nxt),
    .ccr_nxt(ccr_nxt), .mode(oc_mode_e'(mode_q)), .clr(wr_fclr),
    .pin(pin_out), .flag(match_flag));

  // R9
  arr_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !uev) |=> $stable(arr_act));
  // R1
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_ctrl) |=> $stable(pin_out));
endmodule

// File: tb/tmr_oc_pwm_test.sv
module tmr_oc_pwm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        pin_out, match_flag;

  int n_chk = 0;
  int n_bad = 0;
  int hi_n, rise_n, chg_n;

  localparam logic [15:0] EN  = 16'h0010;
  localparam logic [15:0] PRE = 16'h0008;

  always #10 clk = ~clk;

  tmr_oc_pwm uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pin_out(pin_out), .match_flag(match_flag));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input int n);
    logic prev;
    hi_n = 0; rise_n = 0; chg_n = 0;
    @(negedge clk);
    prev = pin_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin_out) hi_n++;
      if (pin_out && !prev) rise_n++;
      if (pin_out != prev) chg_n++;
      prev = pin_out;
    end
  endtask

  task automatic wait_fall();
    logic prev;
    @(negedge clk);
    prev = pin_out;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (prev && !pin_out) break;
      prev = pin_out;
    end
  endtask

  task automatic t_reset();
    idle(2);
    check("R10 pin after reset", pin_out, 0);
    check("R10 flag after reset", match_flag, 0);
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic t_pwm();
    wr(3'd0, 16'd1); wr(3'd1, 16'd9); wr(3'd2, 16'd3);
    wr(3'd3, EN | 16'd6);
    idle(40); measure(200);
    check("R6 pwm1 high clocks", hi_n, 60);
    check("R2 periods per window", rise_n, 10);
    wr(3'd3, EN | 16'd7);
    idle(40); measure(200);
    check("R7 pwm2 high clocks", hi_n, 140);
    wr(3'd2, 16'd0); wr(3'd3, EN | 16'd6);
    idle(40); measure(200);
    check("R6 pwm1 ccr=0", hi_n, 0);
    wr(3'd3, EN | 16'd7);
    idle(40); measure(200);
    check("R7 pwm2 ccr=0", hi_n, 200);
    wr(3'd2, 16'd20); wr(3'd3, EN | 16'd6);
    idle(40); measure(200);
    check("R6 pwm1 ccr>arr", hi_n, 200);
    wr(3'd3, EN | 16'd7);
    idle(40); measure(200);
    check("R7 pwm2 ccr>arr", hi_n, 0);
  endtask

  task automatic t_flag();
    wr(3'd4, 16'd0);
    idle(100);
    check("R3 no flag when ccr>arr", match_flag, 0);
    wr(3'd2, 16'd3);
    idle(30);
    check("R3 flag set on match", match_flag, 1);
    idle(50);
    check("R3 flag sticky", match_flag, 1);
    wr(3'd3, 16'd6);
    wr(3'd4, 16'd0);
    check("R3 flag cleared", match_flag, 0);
    idle(30);
    check("R3 flag stays clear while stopped", match_flag, 0);
  endtask

  task automatic t_stop();
    measure(100);
    check("R1 stopped pin frozen", chg_n, 0);
  endtask

  task automatic t_oc_modes();
    wr(3'd0, 16'd0); wr(3'd1, 16'd9); wr(3'd2, 16'd4);
    wr(3'd3, EN | 16'd3);
    idle(20); measure(200);
    check("R4 toggle count", chg_n, 20);
    check("R1 toggle high clocks", hi_n, 100);
    wr(3'd3, EN | 16'd0);
    measure(100);
    check("R5 frozen no change", chg_n, 0);
    wr(3'd3, EN | 16'd2);
    idle(30);
    check("R5 clear on match", pin_out, 0);
    wr(3'd3, EN | 16'd1);
    idle(30);
    check("R5 set on match", pin_out, 1);
  endtask

  task automatic t_preload();
    wr(3'd3, 16'd0);
    wr(3'd0, 16'd1); wr(3'd1, 16'd9); wr(3'd2, 16'd3);
    wr(3'd3, EN | PRE | 16'd6);
    idle(40);
    wait_fall();
    cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 16'd7;
    @(negedge clk);
    cfg_we = 1'b0;
    hi_n = 0;
    for (int i = 0; i < 10; i++) begin
      if (pin_out) hi_n++;
      @(negedge clk);
    end
    check("R8 buffered ccr no glitch", hi_n, 0);
    idle(40); measure(200);
    check("R8 buffered ccr applied", hi_n, 140);
    wr(3'd3, EN | 16'd6);
    wait_fall();
    cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 16'd9;
    @(negedge clk);
    cfg_we = 1'b0;
    hi_n = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (pin_out) hi_n++;
    end
    check("R8 immediate ccr re-raises pin", (hi_n > 0) ? 1 : 0, 1);
  endtask

  task automatic t_arr();
    wr(3'd3, EN | PRE | 16'd6);
    wr(3'd1, 16'd4); wr(3'd2, 16'd2);
    idle(40); measure(200);
    check("R9 new limit period", rise_n, 20);
    check("R9 new limit high clocks", hi_n, 80);
  endtask

  task automatic t_reset_mid();
    wr(3'd3, EN | 16'd7);
    idle(30);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 pin after mid-run reset", pin_out, 0);
    check("R10 flag after mid-run reset", match_flag, 0);
  endtask

  initial begin
    t_reset();
    t_pwm();
    t_flag();
    t_stop();
    t_oc_modes();
    t_preload();
    t_arr();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule